// File: doc/BRIEF.md
# Temperature Trip Comparator with Release Hysteresis

The block watches a stream of digital temperature readings and keeps three trip flags, one for each programmed limit: a catastrophic limit, a hot limit and an auxiliary limit. A flag is raised when a reading reaches its limit. Once raised, it drops only when the reading has fallen below the limit by a programmable number of LSBs. This margin prevents the flag from chattering when the temperature sits close to the limit.

Readings are considered only on cycles where the valid strobe is high. Between readings the flags keep their value. A mode input selects how the limits are used:

- In per-limit mode, each flag uses its own programmed limit.
- In derived mode, the hot limit is computed as the catastrophic limit minus a programmed offset, and the auxiliary flag is held inactive.

A select input routes either the catastrophic flag or the hot flag to a single combined trip output. A global enable clears every flag while it is low.

Top module: `thermal_trip_cmp`

## Requirements
- R1: After reset is asserted (rst_ni low), all three flags (trip_o bit 0 catastrophic, bit 1 hot, bit 2 auxiliary) and sel_trip_o are 0.
- R2: With en_i high and sample_vld_i high, a clear flag becomes 1 at the next clock edge when sample_i is greater than or equal to that flag's effective limit.
- R3: A set flag clears at a valid sample only when sample_i plus hyst_i (a 0 to 15 LSB margin, evaluated without overflow) is below the effective limit. hyst_i of 0 means release as soon as sample_i is below the limit. Otherwise the flag stays set.
- R4: On cycles where sample_vld_i is low and en_i is high, trip_o is unchanged at the next edge.
- R5: While en_i is low, all flags clear at the next clock edge and stay 0 whatever the samples are.
- R6: sel_trip_o equals trip_o bit 0 when sel_hot_i is 0 and trip_o bit 1 when sel_hot_i is 1, in the same cycle.
- R7: With thermo_mode_i low (derived mode), the hot effective limit is cat_thr_i minus hot_ofs_i, saturated at 0. The auxiliary flag is cleared at the next edge and stays 0.
- R8: With thermo_mode_i high (per-limit mode), the catastrophic, hot and auxiliary flags use cat_thr_i, hot_thr_i and aux_thr_i respectively. The catastrophic flag uses cat_thr_i in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sensor enable; low clears all flags |
| thermo_mode_i | input | 1 | 1 = per-limit mode, 0 = derived mode |
| sel_hot_i | input | 1 | 0 = route catastrophic flag, 1 = route hot flag |
| sample_i | input | TEMP_W | Temperature reading |
| sample_vld_i | input | 1 | Reading valid strobe |
| cat_thr_i | input | TEMP_W | Catastrophic limit |
| hot_thr_i | input | TEMP_W | Hot limit (per-limit mode) |
| aux_thr_i | input | TEMP_W | Auxiliary limit (per-limit mode) |
| hot_ofs_i | input | TEMP_W | Hot distance below catastrophic (derived mode) |
| hyst_i | input | HYST_W | Release margin in LSBs |
| trip_o | output | 3 | Trip flags: bit 0 catastrophic, bit 1 hot, bit 2 auxiliary |
| sel_trip_o | output | 1 | Selected trip flag |

## Verification
The hardest behaviour to reach is the release band: a flag that was already set must see a sample strictly inside the margin window and remain set, and then see the first sample below it and clear. This has to happen with every margin value, including zero and the maximum.

The bench gets there with full upward and then downward ramps of the reading, one valid sample per clock. It repeats the ramps for several margins in both modes, with limits placed so the bands of all three flags are crossed. A derived-mode run with an offset larger than the catastrophic limit exercises the saturation corner.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;
  localparam int N_TRIP  = 3;
  localparam int IDX_CAT = 0;
  localparam int IDX_HOT = 1;
  localparam int IDX_AUX = 2;
endpackage

// File: rtl/thermal_trip_thr.sv
module thermal_trip_thr
  import thermal_trip_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                           thermo_mode_i,
  input  logic [TEMP_W-1:0]              cat_thr_i,
  input  logic [TEMP_W-1:0]              hot_thr_i,
  input  logic [TEMP_W-1:0]              aux_thr_i,
  input  logic [TEMP_W-1:0]              hot_ofs_i,
  output logic [N_TRIP-1:0][TEMP_W-1:0]  thr_o
);
  logic [TEMP_W-1:0] hot_derived;

  // saturate at zero when offset exceeds the catastrophic limit
  always_comb begin
    if (cat_thr_i >= hot_ofs_i) hot_derived = cat_thr_i - hot_ofs_i;
    else                        hot_derived = '0;
  end

  always_comb begin
    thr_o[IDX_CAT] = cat_thr_i;
    thr_o[IDX_HOT] = thermo_mode_i ? hot_thr_i : hot_derived;
    thr_o[IDX_AUX] = aux_thr_i;
  end
endmodule

// File: rtl/thermal_trip_unit.sv
module thermal_trip_unit #(
  parameter int TEMP_W = 8,
  parameter int HYST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [TEMP_W-1:0] sample_i,
  input  logic [TEMP_W-1:0] thr_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic              trip_o
);
  localparam int EXT_W = TEMP_W + 1;

  logic [EXT_W-1:0] sample_hyst;
  logic             set_hit;
  logic             rel_hit;

  assign sample_hyst = {1'b0, sample_i} + EXT_W'(hyst_i);
  assign set_hit     = sample_i >= thr_i;
  assign rel_hit     = sample_hyst < {1'b0, thr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      trip_o <= 1'b0;
    else if (clr_i)   trip_o <= 1'b0;
    else if (upd_i) begin
      if (!trip_o)    trip_o <= set_hit;
      else            trip_o <= !rel_hit;
    end
  end
endmodule

// File: rtl/thermal_trip_cmp.sv
module thermal_trip_cmp
  import thermal_trip_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int HYST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              thermo_mode_i,
  input  logic              sel_hot_i,
  input  logic [TEMP_W-1:0] sample_i,
  input  logic              sample_vld_i,
  input  logic [TEMP_W-1:0] cat_thr_i,
  input  logic [TEMP_W-1:0] hot_thr_i,
  input  logic [TEMP_W-1:0] aux_thr_i,
  input  logic [TEMP_W-1:0] hot_ofs_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic [2:0]        trip_o,
  output logic              sel_trip_o
);
  logic [N_TRIP-1:0][TEMP_W-1:0] thr;

  thermal_trip_thr #(.TEMP_W(TEMP_W)) u_thr (
    .thermo_mode_i (thermo_mode_i),
    .cat_thr_i     (cat_thr_i),
    .hot_thr_i     (hot_thr_i),
    .aux_thr_i     (aux_thr_i),
    .hot_ofs_i     (hot_ofs_i),
    .thr_o         (thr)
  );

  for (genvar g = 0; g < N_TRIP; g++) begin : g_unit
    logic clr;
    // aux limit is meaningless in derived mode
    if (g == IDX_AUX) begin : g_aux
      assign clr = !en_i || !thermo_mode_i;
    end else begin : g_main
      assign clr = !en_i;
    end

    thermal_trip_unit #(.TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_unit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .upd_i    (sample_vld_i),
      .sample_i (sample_i),
      .thr_i    (thr[g]),
      .hyst_i   (hyst_i),
      .trip_o   (trip_o[g])
    );
  end

  assign sel_trip_o = sel_hot_i ? trip_o[IDX_HOT] : trip_o[IDX_CAT];
endmodule

// File: rtl/thermal_trip_chk.sv
module thermal_trip_chk #(
  parameter int TEMP_W = 8,
  parameter int HYST_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              thermo_mode_i,
  input logic              sel_hot_i,
  input logic [TEMP_W-1:0] sample_i,
  input logic              sample_vld_i,
  input logic [TEMP_W-1:0] cat_thr_i,
  input logic [TEMP_W-1:0] hot_thr_i,
  input logic [TEMP_W-1:0] aux_thr_i,
  input logic [TEMP_W-1:0] hot_ofs_i,
  input logic [HYST_W-1:0] hyst_i,
  input logic [2:0]        trip_o,
  input logic              sel_trip_o
);
  logic [TEMP_W:0] s_ext;
  assign s_ext = {1'b0, sample_i} + (TEMP_W+1)'(hyst_i);

  p_cat_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sample_vld_i && sample_i >= cat_thr_i |=> trip_o[0]);

  p_hot_rel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sample_vld_i && thermo_mode_i && s_ext < {1'b0, hot_thr_i} |=> !trip_o[1]);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !sample_vld_i && thermo_mode_i |=> $stable(trip_o));

  p_dis_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> trip_o == 3'b000);

  p_sel_route_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_trip_o == (sel_hot_i ? trip_o[1] : trip_o[0]));

  p_aux_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thermo_mode_i |=> !trip_o[2]);

  p_aux_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sample_vld_i && thermo_mode_i && sample_i >= aux_thr_i |=> trip_o[2]);
endmodule

bind thermal_trip_cmp thermal_trip_chk #(.TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_chk (.*);

// File: tb/thermal_trip_cmp_tb.sv
module thermal_trip_cmp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TEMP_W = 8;
  localparam int HYST_W = 4;
  localparam int WDOG = 150000;

  logic              clk_i = 0;
  logic              rst_ni = 0;
  logic              en_i = 0;
  logic              thermo_mode_i = 1;
  logic              sel_hot_i = 0;
  logic [TEMP_W-1:0] sample_i = '0;
  logic              sample_vld_i = 0;
  logic [TEMP_W-1:0] cat_thr_i = '0;
  logic [TEMP_W-1:0] hot_thr_i = '0;
  logic [TEMP_W-1:0] aux_thr_i = '0;
  logic [TEMP_W-1:0] hot_ofs_i = '0;
  logic [HYST_W-1:0] hyst_i = '0;
  logic [2:0]        trip_o;
  logic              sel_trip_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [2:0] m;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  thermal_trip_cmp #(.TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (sample %0d)", req, act, exp, sample_i);
    end
  endtask

  function automatic logic nxt(input logic f, input int s, input int thr, input int h);
    if (!f) return s >= thr;
    return !((s + h) < thr);
  endfunction

  // model update at a clock edge, using the inputs present at that edge
  task automatic model_edge();
    int hot_eff;
    if (!en_i) begin
      m = 3'b000;
      return;
    end
    hot_eff = thermo_mode_i ? int'(hot_thr_i)
            : ((cat_thr_i >= hot_ofs_i) ? int'(cat_thr_i) - int'(hot_ofs_i) : 0);
    if (sample_vld_i) begin
      m[0] = nxt(m[0], sample_i, cat_thr_i, hyst_i);
      m[1] = nxt(m[1], sample_i, hot_eff, hyst_i);
      m[2] = nxt(m[2], sample_i, aux_thr_i, hyst_i);
    end
    if (!thermo_mode_i) m[2] = 1'b0;
  endtask

  task automatic step(input string req);
    @(posedge clk_i);
    model_edge();
    #(CLK_PERIOD/4);
    chk(req, trip_o, m);
    chk("R6", sel_trip_o, sel_hot_i ? m[1] : m[0]);
    @(negedge clk_i);
  endtask

  task automatic ramp(input string req);
    for (int i = 0; i < (1 << TEMP_W); i++) begin
      sample_i = TEMP_W'(i); sample_vld_i = 1; sel_hot_i = i[0];
      step(req);
    end
    for (int i = (1 << TEMP_W) - 1; i >= 0; i--) begin
      sample_i = TEMP_W'(i); sample_vld_i = 1; sel_hot_i = i[1];
      step(req);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > WDOG) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int hs[5] = '{0, 1, 3, 6, 15};
    m = 3'b000;
    cat_thr_i = 8'd200; hot_thr_i = 8'd150; aux_thr_i = 8'd100; hot_ofs_i = 8'd40;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", trip_o, 0);
    chk("R1", sel_trip_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    en_i = 1;

    // R2 R3 R8: per-limit mode sweeps; R7: derived mode sweeps
    for (int k = 0; k < 5; k++) begin
      hyst_i = HYST_W'(hs[k]);
      thermo_mode_i = 1;
      ramp("R2 R3 R8");
      thermo_mode_i = 0;
      ramp("R2 R3 R7");
    end

    // R7: offset beyond catastrophic limit saturates the hot limit at 0
    hot_ofs_i = 8'd250; hyst_i = 4'd2; thermo_mode_i = 0;
    ramp("R7 sat");
    hot_ofs_i = 8'd40;

    // R4: hold between samples
    thermo_mode_i = 1; hyst_i = 4'd6;
    sample_i = 8'd210; sample_vld_i = 1; step("R2");
    chk("R2", trip_o, 3'b111);
    sample_i = 8'd0; sample_vld_i = 0;
    for (int i = 0; i < 8; i++) step("R4");
    chk("R4", trip_o, 3'b111);

    // R5: disable clears and blocks setting
    en_i = 0;
    step("R5");
    chk("R5", trip_o, 0);
    sample_i = 8'd255; sample_vld_i = 1;
    for (int i = 0; i < 4; i++) step("R5");
    chk("R5", trip_o, 0);
    en_i = 1;

    // R7: switching to derived mode clears aux without a sample
    sample_i = 8'd120; step("R8");
    chk("R8", trip_o, 3'b100);
    sample_vld_i = 0; thermo_mode_i = 0;
    step("R7");
    chk("R7", trip_o, 3'b000);

    // R1: asynchronous reset mid-trip
    thermo_mode_i = 1; sample_i = 8'd255; sample_vld_i = 1;
    step("R2");
    rst_ni = 0; #1;
    chk("R1", trip_o, 0);
    m = 3'b000;
    @(negedge clk_i); rst_ni = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule